// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer that sits behind a small 16-bit register interface. Software arms it by selecting a clock divisor, loading an 8-bit up-counter and setting the enable bit. The counter advances once per prescaled tick. When it rolls over past 255, an overflow flag is set. In watchdog mode, with the reset enable set, the block also drives a reset request for a fixed number of clock cycles. Software must keep rewriting the counter to stop it from overflowing.

Each register accepts a write only when the upper byte of the written word carries that register's key, so a stray store cannot disturb it. The overflow flag has a two-step clear: software must first read the reset-control register while the flag is set, and only after that does the clear word take effect. A fast forced reset is possible by loading 255, selecting the undivided clock and enabling the timer. The overflow then happens on the first enabled cycle.

Top module: `wdog_keyed`

## Requirements
- R1: After reset, all three registers read 0 and the reset output is low.
- R2: A write to offset 0 whose upper byte is 0xA5 updates mode (bit 6), enable (bit 5) and the clock select (bits SEL_W-1:0). Offset 0 reads back these bits in the same positions, with every other bit 0.
- R3: A write whose upper byte is not the key of the addressed register leaves every register unchanged. A write to any unused offset also leaves every register unchanged.
- R4: A write to offset 2 with upper byte 0x5A loads its low byte into the counter. Offset 2 reads the live count in bits 7:0.
- R5: Select value s divides the clock by 2^floor(s*L/(2^SEL_W-1)), where L is 22 for a 4-bit select and 14 for a 3-bit select. The prescaler is cleared while the timer is disabled, so the first increment comes after exactly one full division period of enabled cycles.
- R6: While the enable bit is clear, the counter holds its value.
- R7: A tick at count 255 wraps the counter to 0 and sets the overflow flag. The flag reads as bit 7 of offset 4.
- R8: On overflow with mode=1 and reset enable=1, the reset output goes high on the next cycle and stays high for exactly PULSE_LEN (8) cycles. In any other case the reset output stays low.
- R9: A write to offset 4 with upper byte 0x5A updates the reset enable from bit 6. The reset enable reads back as bit 6 of offset 4.
- R10: Writing exactly 0xA500 to offset 4 clears the flag only if a read strobe on offset 4 occurred while the flag was set. Without such a read, the flag stays set.
- R11: A counter write in the same cycle as a tick wins over the increment, so periodic reloads keep the timer from overflowing.
- R12: After loading 255 and enabling with select 0, the overflow and the start of the reset pulse follow on the first enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rd | input | 1 | Read strobe; matters only for arming the flag clear |
| reg_addr | input | 3 | Byte offset: 0, 2 or 4 |
| reg_wdata | input | 16 | Write word: key in bits 15:8, value in bits 7:0 |
| reg_rdata | output | 16 | Combinational read of the addressed register |
| wdt_reset_out | output | 1 | Reset request pulse |

## Verification
On every cycle, the assertions check the following:
- The counter holds while disabled.
- Rollover wraps the counter to zero.
- A counter load beats the increment.
- Writes with a wrong key leave the control fields alone.
- An unarmed clear word cannot drop the flag.
- The reset-enable update takes the written bit.
- The reset pulse starts after a qualifying overflow and cannot rise without one.

The bench scenarios are needed for the rest. These are the divisor that each select value produces, the exact eight-cycle pulse width, the read-then-clear ordering, and keepalive reloads holding off overflow over many periods. A behavioural model compares the read data and the reset output every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam logic [7:0]  KEY_CTRL  = 8'hA5;
  localparam logic [7:0]  KEY_COUNT = 8'h5A;
  localparam logic [7:0]  KEY_RCTL  = 8'h5A;
  localparam logic [15:0] FLAG_CLEAR_WORD = 16'hA500;

  localparam logic [2:0] OFS_CTRL  = 3'd0;
  localparam logic [2:0] OFS_COUNT = 3'd2;
  localparam logic [2:0] OFS_RCTL  = 3'd4;

  function automatic int max_div_log2(input int sel_w);
    return (sel_w >= 4) ? 22 : 14;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int SEL_W    = 4,
  parameter int DIV_LOG2 = 22
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int PW      = DIV_LOG2;
  localparam int SEL_MAX = (1 << SEL_W) - 1;

  logic [PW-1:0] pre_q, pre_d;
  logic [PW:0]   mask;
  int            shamt;

  always_comb begin
    shamt = (int'(sel) * DIV_LOG2) / SEL_MAX;
    mask  = ((PW+1)'(1) << shamt) - (PW+1)'(1);
    pre_d = run ? pre_q + PW'(1) : '0;
    tick  = run && (({1'b0, pre_q} & mask) == mask);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       load,
  input  logic [7:0] load_val,
  output logic [7:0] count,
  output logic       wrap
);
  logic [7:0] cnt_q, cnt_d;
  logic       cnt_en;

  always_comb begin
    cnt_en = load || tick;
    wrap   = tick && !load && (cnt_q == 8'hFF);
    cnt_d  = load ? load_val : cnt_q + 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(cnt_q));

  // R7
  ovf_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt_q == 8'h00));

  // R11
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int PULSE_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic pulse
);
  localparam int PW = $clog2(PULSE_LEN + 1);

  logic [PW-1:0] left_q, left_d;
  logic          left_en;

  always_comb begin
    left_en = fire || (left_q != '0);
    left_d  = fire ? PW'(PULSE_LEN) : left_q - PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign pulse = (left_q != '0);

  // R8
  pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pulse);

  // R8
  pulse_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulse && !fire) |=> !pulse);
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic             rd,
  input  logic [2:0]       addr,
  input  logic [15:0]      wdata,
  input  logic [7:0]       count,
  input  logic             wrap,
  output logic [15:0]      rdata,
  output logic             run,
  output logic [SEL_W-1:0] sel,
  output logic             load,
  output logic [7:0]       load_val,
  output logic             fire
);
  logic             en_q, en_d, mode_q, mode_d, rsten_q, rsten_d;
  logic             flag_q, flag_d, armed_q, armed_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             ctrl_we, rctl_we, clr_req, peek;
  logic [4:0]       sel_ext;

  always_comb begin
    ctrl_we  = wr && (addr == OFS_CTRL)  && (wdata[15:8] == KEY_CTRL);
    load     = wr && (addr == OFS_COUNT) && (wdata[15:8] == KEY_COUNT);
    rctl_we  = wr && (addr == OFS_RCTL)  && (wdata[15:8] == KEY_RCTL);
    clr_req  = wr && (addr == OFS_RCTL)  && (wdata == FLAG_CLEAR_WORD);
    peek     = rd && (addr == OFS_RCTL)  && flag_q;
    load_val = wdata[7:0];

    en_d    = ctrl_we ? wdata[5] : en_q;
    mode_d  = ctrl_we ? wdata[6] : mode_q;
    sel_d   = ctrl_we ? wdata[SEL_W-1:0] : sel_q;
    rsten_d = rctl_we ? wdata[6] : rsten_q;

    flag_d  = flag_q;
    armed_d = armed_q || peek;
    if (clr_req && armed_q) begin
      flag_d  = 1'b0;
      armed_d = 1'b0;
    end
    if (wrap) flag_d = 1'b1;

    fire = wrap && mode_q && rsten_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      sel_q   <= '0;
      rsten_q <= 1'b0;
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      en_q    <= en_d;
      mode_q  <= mode_d;
      sel_q   <= sel_d;
      rsten_q <= rsten_d;
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    sel_ext = 5'(sel_q);
    case (addr)
      OFS_CTRL:  rdata = {8'h00, 1'b0, mode_q, en_q, sel_ext};
      OFS_COUNT: rdata = {8'h00, count};
      OFS_RCTL:  rdata = {8'h00, flag_q, rsten_q, 6'b0};
      default:   rdata = 16'h0000;
    endcase
  end

  assign run = en_q;
  assign sel = sel_q;

  // R3
  ctrl_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (addr == OFS_CTRL) && (wdata[15:8] != KEY_CTRL))
      |=> $stable({en_q, mode_q, sel_q}));

  // R10
  clr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !armed_q && flag_q) |=> flag_q);

  // R9
  rctl_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rctl_we |=> (rsten_q == $past(wdata[6])));
endmodule

// File: rtl/wdog_keyed.sv
module wdog_keyed
  import wdog_pkg::*;
#(
  parameter int SEL_W     = 4,
  parameter int PULSE_LEN = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  output logic        wdt_reset_out
);
  localparam int DIV_LOG2 = max_div_log2(SEL_W);

  logic             rst_meta, rst_sync;
  logic             run, tick, load, wrap, fire;
  logic [SEL_W-1:0] sel;
  logic [7:0]       load_val, count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  wdog_regs #(.SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_sync), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .count(count), .wrap(wrap), .rdata(reg_rdata),
    .run(run), .sel(sel), .load(load), .load_val(load_val), .fire(fire)
  );

  wdog_prescaler #(.SEL_W(SEL_W), .DIV_LOG2(DIV_LOG2)) u_pre (
    .clk(clk), .rst_n(rst_sync), .run(run), .sel(sel), .tick(tick)
  );

  wdog_counter u_cnt (
    .clk(clk), .rst_n(rst_sync), .run(run), .tick(tick), .load(load),
    .load_val(load_val), .count(count), .wrap(wrap)
  );

  wdog_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_sync), .fire(fire), .pulse(wdt_reset_out)
  );
endmodule

// File: tb/wdog_keyed_tb.sv
module wdog_keyed_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'h0;
  logic [15:0] reg_rdata;
  logic        wdt_reset_out;

  int n_cmp = 0, n_bad = 0, high_cycles = 0;
  bit done = 0;

  // reference model state
  bit m_en, m_mode, m_rsten, m_flag, m_armed;
  int m_sel, m_cnt, m_pulse;
  longint m_pcnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_keyed u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .wdt_reset_out(wdt_reset_out)
  );

  function automatic int model_read(input int a);
    case (a)
      0: return (int'(m_mode) << 6) | (int'(m_en) << 5) | m_sel;
      2: return m_cnt;
      4: return (int'(m_flag) << 7) | (int'(m_rsten) << 6);
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin : model
    int div;
    bit tick, ovf, ld;
    if (!rst_n) begin
      m_en = 0; m_mode = 0; m_rsten = 0; m_flag = 0; m_armed = 0;
      m_sel = 0; m_cnt = 0; m_pulse = 0; m_pcnt = 0;
    end else begin
      div  = 1 << ((m_sel * 22) / 15);
      tick = m_en && ((m_pcnt % div) == div - 1);
      ld   = reg_wr && reg_addr == 2 && reg_wdata[15:8] == 8'h5A;
      ovf  = tick && !ld && m_cnt == 255;
      m_pcnt = m_en ? m_pcnt + 1 : 0;
      if (m_pulse > 0) m_pulse = m_pulse - 1;
      if (ovf && m_mode && m_rsten) m_pulse = 8;
      if (ld) m_cnt = reg_wdata[7:0];
      else if (tick) m_cnt = (m_cnt + 1) % 256;
      if (reg_wr && reg_addr == 4 && reg_wdata == 16'hA500 && m_armed) begin
        m_flag = 0; m_armed = 0;
      end else if (reg_rd && reg_addr == 4 && m_flag) m_armed = 1;
      if (ovf) m_flag = 1;
      if (reg_wr && reg_addr == 0 && reg_wdata[15:8] == 8'hA5) begin
        m_en = reg_wdata[5]; m_mode = reg_wdata[6]; m_sel = reg_wdata[3:0];
      end
      if (reg_wr && reg_addr == 4 && reg_wdata[15:8] == 8'h5A) m_rsten = reg_wdata[6];
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      if (wdt_reset_out) high_cycles++;
      case (reg_addr)
        3'd0: check("R2 ctrl read", int'(reg_rdata), model_read(0));
        3'd2: check("R4 count read", int'(reg_rdata), model_read(2));
        3'd4: check("R7 rctl read", int'(reg_rdata), model_read(4));
        default: check("R3 unused read", int'(reg_rdata), 0);
      endcase
      check("R8 reset out", int'(wdt_reset_out), int'(m_pulse > 0));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic arm_read();
    @(posedge clk); #1;
    reg_addr = 3'd4; reg_rd = 1'b1;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic look(input logic [2:0] a, output int v);
    reg_addr = a; #1;
    v = int'(reg_rdata);
  endtask

  task automatic wait_cyc(input int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int v, h0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    wait_cyc(4);

    // R1 reset state
    look(0, v); check("R1 ctrl", v, 0);
    look(2, v); check("R1 count", v, 0);
    look(4, v); check("R1 rctl", v, 0);
    check("R1 reset out", int'(wdt_reset_out), 0);

    // R3 wrong keys and unused offset
    wr(0, 16'h5A65); wr(2, 16'hA533); wr(4, 16'hA540); wr(6, 16'hA565);
    look(0, v); check("R3 ctrl unchanged", v, 0);
    look(2, v); check("R3 count unchanged", v, 0);
    look(4, v); check("R3 rctl unchanged", v, 0);

    // R2 control write
    wr(0, 16'hA543);
    look(0, v); check("R2 ctrl fields", v, 16'h0043);

    // R4 load, R6 hold while disabled
    wr(2, 16'h5A10);
    look(2, v); check("R4 load", v, 16'h10);
    wait_cyc(6);
    look(2, v); check("R6 hold", v, 16'h10);

    // R5 divisors
    wr(0, 16'hA520); wait_cyc(4);
    look(2, v); check("R5 sel0 div1", v, 16'h14);
    wr(0, 16'hA500); wr(2, 16'h5A00); wr(0, 16'hA522); wait_cyc(8);
    look(2, v); check("R5 sel2 div4", v, 2);
    wr(0, 16'hA500); wr(2, 16'h5A00); wr(0, 16'hA521); wait_cyc(6);
    look(2, v); check("R5 sel1 div2", v, 3);
    wr(0, 16'hA500); look(2, v); h0 = v; wait_cyc(5);
    look(2, v); check("R6 stopped", v, h0);

    // R9 reset enable
    wr(4, 16'h5A40);
    look(4, v); check("R9 rsten", v, 16'h40);

    // R7 overflow in mode 0: flag, no pulse (R8)
    h0 = high_cycles;
    wr(2, 16'h5AFE); wr(0, 16'hA520); wait_cyc(2);
    look(2, v); check("R7 wrap", v, 0);
    look(4, v); check("R7 flag", v, 16'hC0);
    wait_cyc(10);
    check("R8 no pulse in mode0", high_cycles - h0, 0);

    // R10 clear needs prior read
    wr(0, 16'hA500);
    wr(4, 16'hA500);
    look(4, v); check("R10 unarmed clear ignored", v, 16'hC0);
    arm_read();
    wr(4, 16'hA500);
    look(4, v); check("R10 armed clear", v, 16'h40);

    // R12 forced reset, R8 pulse width
    wr(2, 16'h5AFF);
    h0 = high_cycles;
    wr(0, 16'hA560);
    wait_cyc(1);
    check("R12 pulse high", int'(wdt_reset_out), 1);
    look(2, v); check("R12 wrapped", v, 0);
    wait_cyc(11);
    check("R8 pulse width", high_cycles - h0, 8);
    look(4, v); check("R12 flag", v, 16'hC0);

    // R11 keepalive
    h0 = high_cycles;
    for (int i = 0; i < 6; i++) begin
      wr(2, 16'h5AF0);
      look(2, v); check("R11 reload wins", v, 16'hF0);
      wait_cyc(8);
    end
    check("R11 no reset under keepalive", high_cycles - h0, 0);
    wr(0, 16'hA500);
    wait_cyc(2);
    finish_run();
  end
endmodule